// File: doc/BRIEF.md
# Serial Memory and Wiper Command Port

This block is the two-wire serial slave that fronts a small device holding 2 KiB of non-volatile memory and a single volatile wiper register. It oversamples the clock and data lines with a fast system clock and recognises start, repeated start and stop conditions. After a start it decodes an identification byte and then an address byte. Together these give an 11-bit memory address. It acknowledges the bytes it accepts and releases the data line at all other times.

Write data bytes go to a page-write backend, one strobe per byte. A commit pulse on the stop condition tells the backend to start its non-volatile cycle. When the address is all ones, data bytes do not go to the backend. They load the wiper directly. For reads, the master first writes the address, then sends a repeated start and a read identification byte. The slave then streams bytes from an auto-incrementing pointer, fetching each byte from a synchronous memory one cycle after asking for it. A write-protect input, active low, blocks data bytes.

Top module: `serial_mem_port`

## Requirements
- R1: After reset, sdaOe is 0, wiper equals WIPER_RST, and pgWrValid and pgCommit are 0.
- R2: The identification byte has this layout: bits [7:4] are the device code, bits [3:1] are address bits [10:8], and bit 0 is the direction (1 = read). If the code differs from DEV_CODE, the slave gives no ACK and ignores every byte until the next start.
- R3: With a matching code, the slave pulls SDA low during the ninth clock after the identification byte and after the address byte.
- R4: When wpN is high and the address is not all ones, each data byte is ACKed. It is then presented on pgWr for one cycle, with pgWrAddr = {id[3:1], address byte}.
- R5: Successive data bytes in one write advance only the low 4 address bits, wrapping inside the 16-byte page.
- R6: pgCommit pulses once on a stop that ends a write which had at least one full data byte accepted for the backend. A repeated start discards that pending commit. A stop after a read, or after only a partial data byte, gives no pulse.
- R7: When all 11 address bits are ones, each data byte loads its low WIPER_W bits into wiper on the SCL fall that ends its LSB. The byte is ACKed and nothing is sent to pgWr.
- R8: When wpN is low, a data byte is not ACKed, does not reach pgWr or wiper, and the bytes after it are ignored until the next start.
- R9: After a read identification byte, the slave sends the byte at the pointer MSB first, one bit per SCL low phase.
- R10: Each master ACK in the ninth clock advances the pointer by one, with the 11-bit address wrapping from 0x7FF to 0x000, and the next byte follows.
- R11: After a master NACK, the slave keeps SDA released.
- R12: A start or stop in the middle of a byte aborts the transfer and restarts the bit count. The next full transaction then decodes correctly.
- R13: sdaOe only changes while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level (wired bus) |
| wpN | input | 1 | Write-protect, low blocks data bytes |
| sdaOe | output | 1 | Pull SDA low when 1 |
| memRdEn | output | 1 | Read request to synchronous memory |
| memAddr | output | 11 | Read address (pointer) |
| memRdData | input | 8 | Read data, valid the cycle after memRdEn |
| pgWrValid | output | 1 | One-cycle strobe per accepted data byte |
| pgWrAddr | output | 11 | Address of the accepted byte |
| pgWrData | output | 8 | Accepted data byte |
| pgCommit | output | 1 | Stop-triggered commit pulse for the page backend |
| wiper | output | WIPER_W | Volatile wiper register |

## Verification
The bench sweeps the start offset across a whole page and writes three bytes from each offset. A design that ran the pointer across the page boundary, or incremented it outside the page, would report wrong backend addresses near offsets 14 and 15. Sequential reads are run across the top of the address space, where a pointer that saturated or that truncated the upper three bits would return the wrong bytes. The wiper is sampled in the low phase just after the LSB clock, so a design that loaded it at stop, or one clock late, shows the old value. Protected writes, device-code mismatches, repeated starts after data and starts or stops mid-byte are each followed by checks on the backend strobe, the commit count and the ACK level. These catch a design that leaks a byte or a commit in those cases.

// File: rtl/serial_mem_pkg.sv
package serial_mem_pkg;
  localparam int ID_HI_W = 3;
  localparam int MEM_AW  = 8 + ID_HI_W;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ID, ST_ADDR, ST_WDATA, ST_ACK, ST_TX, ST_RACK
  } busState_t;

  typedef struct packed {
    logic shiftIn;
    logic setHi;
    logic setLo;
    logic pageInc;
    logic ptrInc;
    logic fetch;
    logic txShift;
    logic wiperLoad;
    logic pgWrite;
  } dpCmd_t;
endpackage

// File: rtl/smp_bus_sync.sv
module smp_bus_sync (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclHigh,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);
  logic sclMeta, sclSync, sclPrev;
  logic sdaMeta, sdaSync, sdaPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclMeta <= 1'b1; sclSync <= 1'b1; sclPrev <= 1'b1;
      sdaMeta <= 1'b1; sdaSync <= 1'b1; sdaPrev <= 1'b1;
    end else begin
      sclMeta <= sclIn;  sclSync <= sclMeta; sclPrev <= sclSync;
      sdaMeta <= sdaIn;  sdaSync <= sdaMeta; sdaPrev <= sdaSync;
    end
  end

  assign sclHigh  = sclSync;
  assign sdaLvl   = sdaSync;
  assign sclRise  = sclSync & ~sclPrev;
  assign sclFall  = ~sclSync & sclPrev;
  assign startDet = sclSync & sclPrev & sdaPrev & ~sdaSync;
  assign stopDet  = sclSync & sclPrev & ~sdaPrev & sdaSync;
endmodule

// File: rtl/smp_ctrl.sv
module smp_ctrl
  import serial_mem_pkg::*;
#(
  parameter logic [3:0] DEV_CODE = 4'hA
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   sclRise,
  input  logic   sclFall,
  input  logic   startDet,
  input  logic   stopDet,
  input  logic   sdaLvl,
  input  logic   wpN,
  input  logic [7:0] rxByte,
  input  logic   ptrAllOnes,
  output dpCmd_t cmd,
  output logic   ackDrive,
  output logic   txDrive,
  output logic   pgCommit
);
  busState_t state, afterAck;
  logic [3:0] bitCnt;
  logic dirty, masterAck;
  logic byteDone, codeMatch, txDone;

  assign byteDone  = sclFall && (bitCnt == 4'd8);
  assign txDone    = byteDone;
  assign codeMatch = (rxByte[7:4] == DEV_CODE);
  assign txDrive   = (state == ST_TX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      afterAck  <= ST_IDLE;
      bitCnt    <= '0;
      dirty     <= 1'b0;
      masterAck <= 1'b0;
      ackDrive  <= 1'b0;
      pgCommit  <= 1'b0;
    end else begin
      pgCommit <= 1'b0;
      if (stopDet) begin
        state    <= ST_IDLE;
        ackDrive <= 1'b0;
        bitCnt   <= '0;
        pgCommit <= dirty;
        dirty    <= 1'b0;
      end else if (startDet) begin
        state    <= ST_ID;
        ackDrive <= 1'b0;
        bitCnt   <= '0;
        dirty    <= 1'b0;
      end else begin
        unique case (state)
          ST_ID: begin
            if (sclRise && bitCnt != 4'd8) bitCnt <= bitCnt + 4'd1;
            else if (byteDone) begin
              bitCnt <= '0;
              if (!codeMatch) state <= ST_IDLE;
              else begin
                ackDrive <= 1'b1;
                state    <= ST_ACK;
                afterAck <= rxByte[0] ? ST_TX : ST_ADDR;
              end
            end
          end
          ST_ADDR: begin
            if (sclRise && bitCnt != 4'd8) bitCnt <= bitCnt + 4'd1;
            else if (byteDone) begin
              bitCnt   <= '0;
              ackDrive <= 1'b1;
              state    <= ST_ACK;
              afterAck <= ST_WDATA;
            end
          end
          ST_WDATA: begin
            if (sclRise && bitCnt != 4'd8) bitCnt <= bitCnt + 4'd1;
            else if (byteDone) begin
              bitCnt <= '0;
              if (!wpN) state <= ST_IDLE;
              else begin
                ackDrive <= 1'b1;
                state    <= ST_ACK;
                afterAck <= ST_WDATA;
                if (!ptrAllOnes) dirty <= 1'b1;
              end
            end
          end
          ST_ACK: begin
            if (sclFall) begin
              ackDrive <= 1'b0;
              state    <= afterAck;
              bitCnt   <= '0;
            end
          end
          ST_TX: begin
            if (sclRise && bitCnt != 4'd8) bitCnt <= bitCnt + 4'd1;
            else if (txDone) begin
              state  <= ST_RACK;
              bitCnt <= '0;
            end
          end
          ST_RACK: begin
            if (sclRise) masterAck <= ~sdaLvl;
            else if (sclFall) state <= masterAck ? ST_TX : ST_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    cmd = '0;
    if (!stopDet && !startDet) begin
      unique case (state)
        ST_ID: begin
          cmd.shiftIn = sclRise && bitCnt != 4'd8;
          cmd.setHi   = byteDone && codeMatch;
          cmd.fetch   = byteDone && codeMatch && rxByte[0];
        end
        ST_ADDR: begin
          cmd.shiftIn = sclRise && bitCnt != 4'd8;
          cmd.setLo   = byteDone;
        end
        ST_WDATA: begin
          cmd.shiftIn = sclRise && bitCnt != 4'd8;
          if (byteDone && wpN) begin
            cmd.wiperLoad = ptrAllOnes;
            cmd.pgWrite   = ~ptrAllOnes;
            cmd.pageInc   = ~ptrAllOnes;
          end
        end
        ST_TX:   cmd.txShift = sclFall && bitCnt != 4'd8;
        ST_RACK: begin
          cmd.ptrInc = sclRise && ~sdaLvl;
          cmd.fetch  = sclRise && ~sdaLvl;
        end
        default: ;
      endcase
    end
  end

  // R12: the bit counter never runs past a full byte
  p_bitcnt_bound_r12: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= 4'd8);
  // R9: slave ACK and slave data never overlap
  p_tx_no_ack_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(ackDrive && state == ST_TX));
endmodule

// File: rtl/smp_datapath.sv
module smp_datapath
  import serial_mem_pkg::*;
#(
  parameter int WIPER_W   = 7,
  parameter int WIPER_RST = 64,
  parameter int PAGE_W    = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCmd_t             cmd,
  input  logic               sdaLvl,
  output logic [7:0]         rxByte,
  output logic               txBit,
  output logic               ptrAllOnes,
  output logic               memRdEn,
  output logic [MEM_AW-1:0]  memAddr,
  input  logic [7:0]         memRdData,
  output logic               pgWrValid,
  output logic [MEM_AW-1:0]  pgWrAddr,
  output logic [7:0]         pgWrData,
  output logic [WIPER_W-1:0] wiper
);
  logic [7:0]        rxShift, txShiftReg;
  logic [MEM_AW-1:0] ptr;
  logic              fetchReq, fetchDone;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift    <= '0;
      txShiftReg <= '1;
      ptr        <= '0;
      fetchReq   <= 1'b0;
      fetchDone  <= 1'b0;
      pgWrValid  <= 1'b0;
      pgWrAddr   <= '0;
      pgWrData   <= '0;
      wiper      <= WIPER_W'(WIPER_RST);
    end else begin
      fetchReq  <= cmd.fetch;
      fetchDone <= fetchReq;
      pgWrValid <= cmd.pgWrite;
      if (cmd.shiftIn) rxShift <= {rxShift[6:0], sdaLvl};
      if (cmd.setHi) ptr[MEM_AW-1:8] <= rxShift[ID_HI_W:1];
      if (cmd.setLo) ptr[7:0] <= rxShift;
      if (cmd.ptrInc) ptr <= ptr + 1'b1;
      else if (cmd.pageInc) ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + 1'b1;
      if (cmd.pgWrite) begin
        pgWrAddr <= ptr;
        pgWrData <= rxShift;
      end
      if (cmd.wiperLoad) wiper <= rxShift[WIPER_W-1:0];
      if (fetchDone) txShiftReg <= memRdData;
      else if (cmd.txShift) txShiftReg <= {txShiftReg[6:0], 1'b1};
    end
  end

  assign rxByte     = rxShift;
  assign txBit      = txShiftReg[7];
  assign ptrAllOnes = &ptr;
  assign memRdEn    = fetchReq;
  assign memAddr    = ptr;

  // R7: the wiper address never reaches the page backend
  p_wiper_not_paged_r7: assert property (@(posedge clk) disable iff (!rstN)
    pgWrValid |-> (pgWrAddr != '1));
  // R10: a fetched byte never lands while the control is shifting out
  p_load_vs_shift_r10: assert property (@(posedge clk) disable iff (!rstN)
    fetchDone |-> !cmd.txShift);
endmodule

// File: rtl/serial_mem_port.sv
module serial_mem_port
  import serial_mem_pkg::*;
#(
  parameter logic [3:0] DEV_CODE  = 4'hA,
  parameter int         WIPER_W   = 7,
  parameter int         WIPER_RST = 64,
  parameter int         PAGE_W    = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  logic               wpN,
  output logic               sdaOe,
  output logic               memRdEn,
  output logic [10:0]        memAddr,
  input  logic [7:0]         memRdData,
  output logic               pgWrValid,
  output logic [10:0]        pgWrAddr,
  output logic [7:0]         pgWrData,
  output logic               pgCommit,
  output logic [WIPER_W-1:0] wiper
);
  logic sclHigh, sdaLvl, sclRise, sclFall, startDet, stopDet;
  logic ackDrive, txDrive, txBit, ptrAllOnes;
  logic [7:0] rxByte;
  dpCmd_t cmd;

  smp_bus_sync u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclHigh(sclHigh), .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  smp_ctrl #(.DEV_CODE(DEV_CODE)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaLvl(sdaLvl), .wpN(wpN),
    .rxByte(rxByte), .ptrAllOnes(ptrAllOnes), .cmd(cmd),
    .ackDrive(ackDrive), .txDrive(txDrive), .pgCommit(pgCommit)
  );

  smp_datapath #(.WIPER_W(WIPER_W), .WIPER_RST(WIPER_RST), .PAGE_W(PAGE_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .sdaLvl(sdaLvl), .rxByte(rxByte),
    .txBit(txBit), .ptrAllOnes(ptrAllOnes), .memRdEn(memRdEn), .memAddr(memAddr),
    .memRdData(memRdData), .pgWrValid(pgWrValid), .pgWrAddr(pgWrAddr),
    .pgWrData(pgWrData), .wiper(wiper)
  );

  assign sdaOe = ackDrive | (txDrive & ~txBit);

  // R13: the slave only moves SDA while the synchronised clock is low
  p_sda_moves_low_r13: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclHigh);
  // R8: no backend byte follows a cycle with write-protect active
  p_wp_blocks_r8: assert property (@(posedge clk) disable iff (!rstN)
    pgWrValid |-> $past(wpN));
endmodule

// File: tb/serial_mem_port_tb.sv
module serial_mem_port_tb;
  localparam int HALF = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1, mSda = 1'b1, wpN = 1'b1;
  logic sdaOe, memRdEn, pgWrValid, pgCommit;
  logic [10:0] memAddr, pgWrAddr;
  logic [7:0] memRdData, pgWrData;
  logic [6:0] wiper;
  logic sdaBus;

  int total = 0, fails = 0, wrCnt = 0, commitCnt = 0, sdaViol = 0;
  logic [10:0] logAddr [0:63];
  logic [7:0]  logData [0:63];
  logic [7:0]  ram [0:2047];
  logic lastOe = 1'b0;

  always #5 clk = ~clk;
  assign sdaBus = mSda & ~sdaOe;

  serial_mem_port u_dut (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaBus), .wpN(wpN),
    .sdaOe(sdaOe), .memRdEn(memRdEn), .memAddr(memAddr), .memRdData(memRdData),
    .pgWrValid(pgWrValid), .pgWrAddr(pgWrAddr), .pgWrData(pgWrData),
    .pgCommit(pgCommit), .wiper(wiper)
  );

  function automatic logic [7:0] patt(input int a);
    return 8'((a * 13) + (a >> 8) * 5 + 1);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 2048; i++) ram[i] <= patt(i);
      memRdData <= '0;
    end else begin
      if (pgWrValid) begin
        ram[pgWrAddr] <= pgWrData;
        logAddr[wrCnt % 64] <= pgWrAddr;
        logData[wrCnt % 64] <= pgWrData;
        wrCnt <= wrCnt + 1;
      end
      if (pgCommit) commitCnt <= commitCnt + 1;
      if (memRdEn) memRdData <= ram[memAddr];
      if (sdaOe !== lastOe && mScl) sdaViol <= sdaViol + 1;
      lastOe <= sdaOe;
    end
  end

  task automatic checkEq(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic halfWait();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic busStart();
    mSda = 1'b1; halfWait(); mScl = 1'b1; halfWait();
    mSda = 1'b0; halfWait(); mScl = 1'b0; halfWait();
  endtask

  task automatic busStop();
    mSda = 1'b0; halfWait(); mScl = 1'b1; halfWait(); mSda = 1'b1; halfWait();
  endtask

  task automatic sendBit(input logic b);
    mSda = b; halfWait(); mScl = 1'b1; halfWait(); mScl = 1'b0;
  endtask

  task automatic sendBits(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
  endtask

  task automatic ackClock(output logic ack);
    mSda = 1'b1; halfWait(); mScl = 1'b1;
    repeat (HALF / 2) @(negedge clk);
    ack = ~sdaBus;
    repeat (HALF - HALF / 2) @(negedge clk);
    mScl = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    sendBits(b); ackClock(ack);
  endtask

  task automatic readByte(output logic [7:0] d, input logic giveAck);
    mSda = 1'b1;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      halfWait(); mScl = 1'b1;
      repeat (HALF / 2) @(negedge clk);
      d = {d[6:0], sdaBus};
      repeat (HALF - HALF / 2) @(negedge clk);
      mScl = 1'b0;
    end
    mSda = giveAck ? 1'b0 : 1'b1;
    halfWait(); mScl = 1'b1; halfWait(); mScl = 1'b0;
    mSda = 1'b1;
  endtask

  task automatic readSeq(input int addr, input int n, input string req);
    logic a;
    logic [7:0] d;
    logic [7:0] idW;
    idW = 8'hA0 | 8'((addr >> 8) << 1);
    busStart();
    sendByte(idW, a);          checkEq({req, " id ack"}, a, 1);
    sendByte(8'(addr), a);     checkEq({req, " addr ack"}, a, 1);
    busStart();
    sendByte(idW | 8'h01, a);  checkEq({req, " read id ack"}, a, 1);
    for (int k = 0; k < n; k++) begin
      readByte(d, k < n - 1);
      checkEq({req, " data"}, d, patt((addr + k) % 2048));
    end
    busStop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] d;
    int wb, cb;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    checkEq("R1 sdaOe", sdaOe, 0);
    checkEq("R1 wiper", wiper, 64);
    checkEq("R1 pgWrValid", pgWrValid, 0);
    checkEq("R1 pgCommit", pgCommit, 0);

    // R2 device code mismatch
    wb = wrCnt; cb = commitCnt;
    busStart();
    sendByte(8'h50, a); checkEq("R2 mismatch id ack", a, 0);
    sendByte(8'h10, a); checkEq("R2 later byte ack", a, 0);
    sendByte(8'h33, a); checkEq("R2 later byte ack", a, 0);
    busStop(); repeat (5) @(negedge clk);
    checkEq("R2 no writes", wrCnt, wb);
    checkEq("R2 no commit", commitCnt, cb);

    // R3 R4 R5 R6 page sweep over every start offset
    for (int off = 0; off < 16; off++) begin
      logic allAck;
      wb = wrCnt; cb = commitCnt;
      allAck = 1'b1;
      busStart();
      sendByte(8'hA4, a); allAck &= a;
      sendByte(8'(8'h30 + off), a); allAck &= a;
      for (int k = 0; k < 3; k++) begin
        sendByte(8'(off * 3 + k), a); allAck &= a;
      end
      busStop(); repeat (5) @(negedge clk);
      checkEq("R3 acks in write", allAck, 1);
      checkEq("R4 byte count", wrCnt - wb, 3);
      for (int k = 0; k < 3; k++) begin
        checkEq("R5 page address", logAddr[(wb + k) % 64], 11'h230 | ((off + k) % 16));
        checkEq("R4 data", logData[(wb + k) % 64], (off * 3 + k) % 256);
      end
      checkEq("R6 commit once", commitCnt - cb, 1);
    end

    // R9 read back bytes written by the sweep
    busStart();
    sendByte(8'hA4, a); sendByte(8'h30, a);
    busStart();
    sendByte(8'hA5, a); checkEq("R9 read id ack", a, 1);
    readByte(d, 1'b1); checkEq("R9 readback 0x230", d, 46);
    readByte(d, 1'b0); checkEq("R10 readback 0x231", d, 47);
    busStop();

    // R7 wiper at all-ones address, loaded at the LSB fall
    wb = wrCnt; cb = commitCnt;
    busStart();
    sendByte(8'hAE, a); checkEq("R7 id ack", a, 1);
    sendByte(8'hFF, a); checkEq("R7 addr ack", a, 1);
    sendBits(8'h35);
    repeat (6) @(negedge clk);
    checkEq("R7 wiper after LSB fall", wiper, 8'h35 & 8'h7F);
    ackClock(a); checkEq("R7 wiper byte ack", a, 1);
    sendByte(8'hC8, a);
    checkEq("R7 second wiper byte", wiper, 8'h48);
    busStop(); repeat (5) @(negedge clk);
    checkEq("R7 no backend write", wrCnt, wb);
    checkEq("R7 no commit", commitCnt, cb);

    // R8 write protect
    wpN = 1'b0;
    wb = wrCnt; cb = commitCnt;
    busStart();
    sendByte(8'hA2, a); checkEq("R8 id ack", a, 1);
    sendByte(8'h40, a); checkEq("R8 addr ack", a, 1);
    sendByte(8'h11, a); checkEq("R8 data nack", a, 0);
    sendByte(8'h22, a); checkEq("R8 next byte ignored", a, 0);
    busStop();
    busStart();
    sendByte(8'hAE, a); sendByte(8'hFF, a);
    sendByte(8'h05, a); checkEq("R8 wiper byte nack", a, 0);
    busStop(); repeat (5) @(negedge clk);
    checkEq("R8 wiper unchanged", wiper, 8'h48);
    checkEq("R8 no backend write", wrCnt, wb);
    checkEq("R8 no commit", commitCnt, cb);
    wpN = 1'b1;

    // R6 repeated start discards the pending commit
    wb = wrCnt; cb = commitCnt;
    busStart();
    sendByte(8'hA2, a); sendByte(8'h50, a); sendByte(8'h99, a);
    checkEq("R6 data ack", a, 1);
    busStart();
    busStop(); repeat (5) @(negedge clk);
    checkEq("R6 byte passed", wrCnt - wb, 1);
    checkEq("R6 no commit after restart", commitCnt, cb);

    // R12 start in the middle of a byte
    wb = wrCnt; cb = commitCnt;
    busStart();
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1); sendBit(1'b0);
    busStart();
    sendByte(8'hA2, a); checkEq("R12 id ack after abort", a, 1);
    sendByte(8'h77, a);
    sendByte(8'h5A, a); checkEq("R12 data ack", a, 1);
    busStop(); repeat (5) @(negedge clk);
    checkEq("R12 address", logAddr[wb % 64], 11'h177);
    checkEq("R12 data", logData[wb % 64], 8'h5A);
    checkEq("R12 commit", commitCnt - cb, 1);

    // R12 stop in the middle of a data byte
    wb = wrCnt; cb = commitCnt;
    busStart();
    sendByte(8'hA2, a); sendByte(8'h60, a);
    sendBit(1'b1); sendBit(1'b1); sendBit(1'b0);
    busStop(); repeat (5) @(negedge clk);
    checkEq("R12 partial byte dropped", wrCnt, wb);
    checkEq("R6 partial byte no commit", commitCnt, cb);

    // R9 R10 sequential reads, including address wrap
    cb = commitCnt;
    readSeq(11'h000, 4, "R9 read 0x000");
    readSeq(11'h3A5, 3, "R10 read 0x3A5");
    readSeq(11'h7FD, 4, "R10 wrap 0x7FD");
    checkEq("R6 no commit after reads", commitCnt, cb);

    // R11 after NACK the slave stays off the bus
    busStart();
    sendByte(8'hA0, a); sendByte(8'h10, a);
    busStart();
    sendByte(8'hA1, a);
    readByte(d, 1'b0);
    checkEq("R11 last byte", d, patt(11'h010));
    for (int i = 0; i < 2; i++) begin
      halfWait(); mScl = 1'b1;
      repeat (HALF / 2) @(negedge clk);
      checkEq("R11 SDA released", sdaBus, 1);
      repeat (HALF - HALF / 2) @(negedge clk);
      mScl = 1'b0;
    end
    busStop(); repeat (5) @(negedge clk);

    checkEq("R13 SDA moved with SCL high", sdaViol, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule